// File: doc/BRIEF.md
# Multi-Mode Program Bank Mapper

This block sits between a console CPU and a program ROM that is larger than the CPU's address window. It splits the upper window into four 8 KB slots (0x8000, 0xA000, 0xC000, 0xE000) and an optional slot at 0x6000. For each slot it produces the number of the physical 8 KB ROM page that the slot shows. The external address logic joins that number with the low 13 CPU address bits to form the ROM address.

Software programs four 8-bit page registers and one layout control byte over a plain write bus. The layout byte selects one of four arrangements:
- a fixed map onto the top of the ROM,
- a paired 16 KB map driven by one register,
- a direct map that can optionally pin the top slot,
- a reversed map.

One layout can also expose a page at 0x6000. Every page number is reduced modulo the ROM page count. A short ROM therefore wraps and never addresses past its end.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset, page register i holds (PAGES-4+i) and the layout byte is zero. The 0x8000/0xA000/0xC000/0xE000 outputs read PAGES-4, PAGES-3, PAGES-2 and PAGES-1. win6_valid is 0 and page_6000 is 0.
- R2: A write whose address ANDed with 0xF007 equals 0x8000+i (i = 0..3) loads page register i with wr_data. Any other address, including 0x8004, leaves all four page registers unchanged.
- R3: A write whose address ANDed with 0xF007 equals 0xD000 loads the layout byte. Bit 7 is the 0x6000 enable, bit 2 is the top-slot select, and bits 1:0 are the layout code. Bits 6:3 are ignored.
- R4: Layout code 0 maps the four slots, in ascending address order, to pages PAGES-4, PAGES-3, PAGES-2 and PAGES-1, whatever the registers hold.
- R5: Layout code 1 maps 0x8000 to 2*reg1 and 0xA000 to 2*reg1+1. It maps 0xC000 to PAGES-2 and 0xE000 to PAGES-1.
- R6: Layout code 2 with bit 2 set maps the slots 0x8000, 0xA000, 0xC000 and 0xE000 to reg0, reg1, reg2 and reg3.
- R7: Layout code 2 with bit 2 clear maps 0x8000, 0xA000 and 0xC000 to reg0, reg1 and reg2, and pins 0xE000 to PAGES-1.
- R8: win6_valid is 1 only under layout code 2 with bit 2 clear and bit 7 set. page_6000 then shows reg3. In every other case win6_valid is 0 and page_6000 is 0.
- R9: Layout code 3 maps 0x8000, 0xA000, 0xC000 and 0xE000 to reg3, reg2, reg1 and reg0 respectively.
- R10: Every page output equals its selected value modulo PAGES and is always below PAGES.
- R11: The outputs are registered. A write sampled at clock edge k changes the outputs at edge k+1 and not before.
- R12: While wr_en is low, the bus address and data have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle while high |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| page_6000 | output | PAGE_W | Page for the 0x6000 slot (0 when not valid) |
| win6_valid | output | 1 | 0x6000 slot is mapped to ROM |
| page_8000 | output | PAGE_W | Page for the 0x8000 slot |
| page_a000 | output | PAGE_W | Page for the 0xA000 slot |
| page_c000 | output | PAGE_W | Page for the 0xC000 slot |
| page_e000 | output | PAGE_W | Page for the 0xE000 slot |

## Verification
A page-register write and a layout-byte write can fall on adjacent edges. In that case the output register refreshes once from a state where only one of them has landed. The bench provokes this with back-to-back writes that alternate between the layout byte and a register on consecutive cycles. A behavioural model tracks, edge by edge, which writes have landed before each output refresh. Every output is compared against that model on every clock, so a design that refreshed from stale or premature state shows up at the exact cycle.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int NREGS  = 4;

    localparam logic [ADDR_W-1:0] DEC_MASK  = 16'hF007;
    localparam logic [ADDR_W-1:0] BANK_BASE = 16'h8000;
    localparam logic [ADDR_W-1:0] MODE_ADDR = 16'hD000;

    typedef enum logic [1:0] {
        LAY_FIXED   = 2'd0,
        LAY_PAIR    = 2'd1,
        LAY_DIRECT  = 2'd2,
        LAY_REVERSE = 2'd3
    } layout_e;

    typedef struct packed {
        logic    win6_en;
        logic    top_sel;
        layout_e layout;
    } mode_t;

endpackage

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
    import prg_map_pkg::*;
#(
    parameter int PAGES = 48
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [NREGS-1:0][DATA_W-1:0]  bank_q,
    output mode_t                         mode_q
);

    typedef struct packed {
        logic [NREGS-1:0][DATA_W-1:0] bank;
        mode_t                        mode;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [ADDR_W-1:0] masked;
    logic              bank_hit;
    logic              mode_hit;

    always_comb begin
        regs_d   = regs_q;
        masked   = wr_addr & DEC_MASK;
        bank_hit = (masked[ADDR_W-1:2] == BANK_BASE[ADDR_W-1:2]);
        mode_hit = (masked == MODE_ADDR);
        if (wr_en) begin
            if (bank_hit) begin
                regs_d.bank[masked[1:0]] = wr_data;
            end else if (mode_hit) begin
                regs_d.mode.win6_en = wr_data[7];
                regs_d.mode.top_sel = wr_data[2];
                regs_d.mode.layout  = layout_e'(wr_data[1:0]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                regs_q.bank[i] <= DATA_W'(PAGES - NREGS + i);
            end
            regs_q.mode <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bank_q = regs_q.bank;
    assign mode_q = regs_q.mode;

    // R2
    bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bank_hit) |=> (bank_q[$past(masked[1:0])] == $past(wr_data)));

    // R2
    bank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && bank_hit) |=> $stable(bank_q));

    // R3
    mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode_hit) |=> (mode_q.layout == $past(wr_data[1:0]) &&
                                 mode_q.win6_en == $past(wr_data[7]) &&
                                 mode_q.top_sel == $past(wr_data[2])));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q));

endmodule

// File: rtl/prg_page_resolve.sv
module prg_page_resolve
    import prg_map_pkg::*;
#(
    parameter int PAGES  = 48,
    parameter int PAGE_W = 6
) (
    input  logic [NREGS-1:0][DATA_W-1:0] bank,
    input  mode_t                        mode,
    output logic [PAGE_W-1:0]            pg6,
    output logic                         pg6_ok,
    output logic [PAGE_W-1:0]            pg8,
    output logic [PAGE_W-1:0]            pga,
    output logic [PAGE_W-1:0]            pgc,
    output logic [PAGE_W-1:0]            pge
);

    localparam logic [PAGE_W-1:0] LAST0 = PAGE_W'(PAGES - 4);
    localparam logic [PAGE_W-1:0] LAST1 = PAGE_W'(PAGES - 3);
    localparam logic [PAGE_W-1:0] LAST2 = PAGE_W'(PAGES - 2);
    localparam logic [PAGE_W-1:0] LAST3 = PAGE_W'(PAGES - 1);

    function automatic logic [PAGE_W-1:0] wrap(input logic [DATA_W:0] v);
        int unsigned r;
        r = 32'(v) % 32'(PAGES);
        return PAGE_W'(r);
    endfunction

    logic [NREGS-1:0][PAGE_W-1:0] reg_pg;
    logic [PAGE_W-1:0]            pair_lo;
    logic [PAGE_W-1:0]            pair_hi;

    generate
        for (genvar g = 0; g < NREGS; g++) begin : g_wrap
            assign reg_pg[g] = wrap({1'b0, bank[g]});
        end
    endgenerate

    assign pair_lo = wrap({bank[1], 1'b0});
    assign pair_hi = wrap({bank[1], 1'b1});

    always_comb begin
        pg6    = '0;
        pg6_ok = 1'b0;
        pg8    = LAST0;
        pga    = LAST1;
        pgc    = LAST2;
        pge    = LAST3;
        unique case (mode.layout)
            LAY_FIXED: begin
            end
            LAY_PAIR: begin
                pg8 = pair_lo;
                pga = pair_hi;
            end
            LAY_DIRECT: begin
                pg8 = reg_pg[0];
                pga = reg_pg[1];
                pgc = reg_pg[2];
                if (mode.top_sel) begin
                    pge = reg_pg[3];
                end else if (mode.win6_en) begin
                    pg6    = reg_pg[3];
                    pg6_ok = 1'b1;
                end
            end
            LAY_REVERSE: begin
                pg8 = reg_pg[3];
                pga = reg_pg[2];
                pgc = reg_pg[1];
                pge = reg_pg[0];
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
    import prg_map_pkg::*;
#(
    parameter int  PAGES  = 48,
    localparam int PAGE_W = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [15:0]       wr_addr,
    input  logic [7:0]        wr_data,
    output logic [PAGE_W-1:0] page_6000,
    output logic              win6_valid,
    output logic [PAGE_W-1:0] page_8000,
    output logic [PAGE_W-1:0] page_a000,
    output logic [PAGE_W-1:0] page_c000,
    output logic [PAGE_W-1:0] page_e000
);

    typedef struct packed {
        logic [PAGE_W-1:0] p6;
        logic              v6;
        logic [PAGE_W-1:0] p8;
        logic [PAGE_W-1:0] pa;
        logic [PAGE_W-1:0] pc;
        logic [PAGE_W-1:0] pe;
    } outs_t;

    logic [NREGS-1:0][DATA_W-1:0] bank_q;
    mode_t                        mode_q;
    outs_t                        outs_d, outs_q;

    prg_bank_regs #(.PAGES(PAGES)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .bank_q (bank_q),
        .mode_q (mode_q)
    );

    prg_page_resolve #(.PAGES(PAGES), .PAGE_W(PAGE_W)) u_resolve (
        .bank  (bank_q),
        .mode  (mode_q),
        .pg6   (outs_d.p6),
        .pg6_ok(outs_d.v6),
        .pg8   (outs_d.p8),
        .pga   (outs_d.pa),
        .pgc   (outs_d.pc),
        .pge   (outs_d.pe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outs_q.p6 <= '0;
            outs_q.v6 <= 1'b0;
            outs_q.p8 <= PAGE_W'(PAGES - 4);
            outs_q.pa <= PAGE_W'(PAGES - 3);
            outs_q.pc <= PAGE_W'(PAGES - 2);
            outs_q.pe <= PAGE_W'(PAGES - 1);
        end else begin
            outs_q <= outs_d;
        end
    end

    assign page_6000  = outs_q.p6;
    assign win6_valid = outs_q.v6;
    assign page_8000  = outs_q.p8;
    assign page_a000  = outs_q.pa;
    assign page_c000  = outs_q.pc;
    assign page_e000  = outs_q.pe;

    // R10
    page_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(page_8000) < PAGES) && (32'(page_a000) < PAGES) &&
        (32'(page_c000) < PAGES) && (32'(page_e000) < PAGES) &&
        (32'(page_6000) < PAGES));

    // R8
    win6_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win6_valid |-> $past(mode_q.layout == LAY_DIRECT && mode_q.win6_en && !mode_q.top_sel));

    // R8
    win6_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win6_valid |-> (page_6000 == '0));

    // R4
    fixed_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_q.layout == LAY_FIXED) |-> (page_e000 == PAGE_W'(PAGES - 1) &&
                                               page_8000 == PAGE_W'(PAGES - 4)));

    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bank_q) == bank_q && $past(mode_q) == mode_q) |=> $stable(outs_q));

endmodule

// File: tb/prg_bank_mapper_bench.sv
module prg_bank_mapper_bench;

    localparam int PAGES  = 48;
    localparam int PAGE_W = $clog2(PAGES);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [15:0]       wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic [PAGE_W-1:0] page_6000, page_8000, page_a000, page_c000, page_e000;
    logic              win6_valid;

    int checks = 0;
    int errors = 0;
    bit model_on = 1'b0;

    int m_bank[4];
    int m_lay;
    bit m_top, m_w6;
    int e6, e8, ea, ec, ee;
    bit ev;
    string etag;

    always #4 clk = ~clk;

    prg_bank_mapper #(.PAGES(PAGES)) u_prg_bank_mapper (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .page_6000(page_6000), .win6_valid(win6_valid), .page_8000(page_8000),
        .page_a000(page_a000), .page_c000(page_c000), .page_e000(page_e000)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) m_bank[i] = PAGES - 4 + i;
        m_lay = 0; m_top = 0; m_w6 = 0;
    endtask

    task automatic model_eval();
        e6 = 0; ev = 0;
        e8 = PAGES - 4; ea = PAGES - 3; ec = PAGES - 2; ee = PAGES - 1;
        case (m_lay)
            0: etag = "R4";
            1: begin
                etag = "R5";
                e8 = (m_bank[1] * 2) % PAGES;
                ea = (m_bank[1] * 2 + 1) % PAGES;
            end
            2: begin
                e8 = m_bank[0] % PAGES; ea = m_bank[1] % PAGES; ec = m_bank[2] % PAGES;
                if (m_top) begin
                    etag = "R6"; ee = m_bank[3] % PAGES;
                end else begin
                    etag = m_w6 ? "R8" : "R7";
                    if (m_w6) begin ev = 1; e6 = m_bank[3] % PAGES; end
                end
            end
            default: begin
                etag = "R9";
                e8 = m_bank[3] % PAGES; ea = m_bank[2] % PAGES;
                ec = m_bank[1] % PAGES; ee = m_bank[0] % PAGES;
            end
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
            model_eval();
        end else begin
            model_eval();
            if (wr_en) begin
                int a;
                a = int'(wr_addr & 16'hF007);
                if (a >= 'h8000 && a <= 'h8003) m_bank[a - 'h8000] = int'(wr_data);
                else if (a == 'hD000) begin
                    m_lay = int'(wr_data[1:0]);
                    m_top = wr_data[2];
                    m_w6  = wr_data[7];
                end
            end
        end
    end

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && model_on) begin
            chk({etag, " R10 R11 page_8000"}, int'(page_8000), e8);
            chk({etag, " R10 R11 page_a000"}, int'(page_a000), ea);
            chk({etag, " R10 R11 page_c000"}, int'(page_c000), ec);
            chk({etag, " R10 R11 page_e000"}, int'(page_e000), ee);
            chk({etag, " R8 win6_valid"}, int'(win6_valid), int'(ev));
            chk({etag, " R8 page_6000"}, int'(page_6000), e6);
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        model_on = 1'b1;
        idle(2);
        // R1 reset map
        chk("R1 page_8000", int'(page_8000), PAGES - 4);
        chk("R1 page_a000", int'(page_a000), PAGES - 3);
        chk("R1 page_c000", int'(page_c000), PAGES - 2);
        chk("R1 page_e000", int'(page_e000), PAGES - 1);
        chk("R1 win6_valid", int'(win6_valid), 0);

        // R9 reverse layout
        wr(16'hD000, 8'h03);
        wr(16'h8000, 8'd5); wr(16'h8001, 8'd6); wr(16'h8002, 8'd7); wr(16'h8003, 8'd9);
        idle(2);
        chk("R9 page_8000", int'(page_8000), 9);
        chk("R9 page_e000", int'(page_e000), 5);

        // R2 masked decode and non-matching address
        wr(16'h8004, 8'd33);
        wr(16'h8FF9, 8'd20);
        idle(2);
        chk("R2 page_e000 unchanged", int'(page_e000), 5);
        chk("R2 page_c000 via alias", int'(page_c000), 20);
        chk("R2 page_a000 unchanged", int'(page_a000), 7);

        // R12 strobe low
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 16'h8000; wr_data = 8'd1;
        idle(2);
        chk("R12 page_e000", int'(page_e000), 5);

        // R11 latency
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 16'h8003; wr_data = 8'd11;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R11 old value held", int'(page_8000), 9);
        @(negedge clk);
        chk("R11 new value", int'(page_8000), 11);

        // R10 wrap
        wr(16'h8000, 8'd200);
        idle(2);
        chk("R10 wrap", int'(page_e000), 200 % PAGES);

        // R5 pair layout
        wr(16'hD008, 8'h01);
        idle(2);
        chk("R5 page_8000", int'(page_8000), 40);
        chk("R5 page_a000", int'(page_a000), 41);
        chk("R5 page_c000", int'(page_c000), PAGES - 2);
        wr(16'h8001, 8'd30);
        idle(2);
        chk("R5 R10 page_8000", int'(page_8000), 60 % PAGES);
        chk("R5 R10 page_a000", int'(page_a000), 61 % PAGES);

        // R6 direct with selectable top
        wr(16'hD000, 8'h06);
        idle(2);
        chk("R6 page_8000", int'(page_8000), 200 % PAGES);
        chk("R6 page_e000", int'(page_e000), 11);

        // R7 direct with pinned top
        wr(16'hD000, 8'h02);
        idle(2);
        chk("R7 page_e000", int'(page_e000), PAGES - 1);
        chk("R7 win6_valid", int'(win6_valid), 0);

        // R8 window at 0x6000
        wr(16'hD000, 8'h82);
        idle(2);
        chk("R8 win6_valid", int'(win6_valid), 1);
        chk("R8 page_6000", int'(page_6000), 11);
        wr(16'hD000, 8'h86);
        idle(2);
        chk("R8 off with top select", int'(win6_valid), 0);
        wr(16'hD000, 8'h83);
        idle(2);
        chk("R8 off in reverse", int'(win6_valid), 0);
        chk("R8 page_6000 zero", int'(page_6000), 0);

        // R3 ignored bits, R4 fixed layout
        wr(16'hD000, 8'h78);
        idle(2);
        chk("R3 R4 page_8000", int'(page_8000), PAGES - 4);
        chk("R3 R4 page_e000", int'(page_e000), PAGES - 1);
        chk("R3 win6_valid", int'(win6_valid), 0);

        // back-to-back writes: layout and registers on consecutive edges
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            wr_en = 1'b1;
            if (k % 2 == 0) begin
                wr_addr = 16'hD000;
                wr_data = 8'((k * 37) ^ 8'h84);
            end else begin
                wr_addr = 16'h8000 + 16'((k / 2) % 4);
                wr_data = 8'(k * 53 + 7);
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        idle(4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule